// File: doc/BRIEF.md
# Compression Engine Host Register Slave

This block is the register front end that a host processor uses to set up and watch an image compression engine. It sits on a 32-bit peripheral bus with a select and acknowledge handshake. The bus master raises select with an address, a direction flag and, on a write, the data. It holds all of them until the slave acknowledges. The slave answers every transfer with a single-cycle acknowledge. Read data is valid in that same cycle. At all other times the read bus is zero, so it can be OR-ed with the read buses of other slaves.

The host programs the frame geometry and two 64-entry quantization tables, one for brightness and one for colour difference. It then writes the control word with its request bit set. That write sends a one-cycle start pulse to the engine and sets the status register to busy. The host polls the status register until it reads the finished code. The engine reports the end of the frame on a done input. Every table write is also forwarded to the engine as a one-cycle write strobe, with the entry index and the 8-bit value.

Top module: `enc_host_regs`

## Requirements
- R1: The acknowledge is high for exactly one cycle: the cycle after the first clock edge at which select is seen high. It is not raised again until select has been low at a clock edge, however long select is held.
- R2: The read bus is zero in every cycle without an acknowledge. In the acknowledge cycle of a read it carries the addressed register.
- R3: A write to byte offset 0x0 (control) stores the whole word, and a read returns it. If bit 0 of the written word is 1, the start output is high for one cycle, the acknowledge cycle. The component count output shows bits 3:1 of the stored word, so writing 7 starts a 3-component frame.
- R4: Offset 0x4 holds the frame size. Width is in bits 31:16 and height in bits 15:0. Both are shown on outputs and read back unchanged.
- R5: Offsets 0x100 + 4*i (i = 0..63) hold brightness table entry i, taken from data bits 7:0. A read returns the entry zero-extended. In the acknowledge cycle of the write, the brightness strobe is high, with index i and the byte on the table outputs.
- R6: Offsets 0x200 + 4*i hold colour-difference table entry i, with the same layout. The colour strobe is used, and the brightness table is left unchanged.
- R7: Status at offset 0xC reads 0 after reset. It reads 1 (busy) from a start until the done input is seen high while busy, then 2 (finished) until the next start. Writing control with bit 0 clear does not change it.
- R8: Reads of unmapped offsets are acknowledged and return zero. Writes to unmapped offsets are acknowledged and change no register.
- R9: The retry, timeout-suppress and error outputs are always low.
- R10: In reset the acknowledge, start, strobes, read bus and all register outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 32 | Byte address of the transfer |
| bus_be | input | 4 | Byte enables (full-word transfers only, not decoded) |
| bus_wdata | input | 32 | Write data from the master |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_sel | input | 1 | Transfer request, held until acknowledge |
| bus_rdata | output | 32 | Read data, zero outside a read acknowledge |
| bus_ack | output | 1 | Single-cycle transfer acknowledge |
| bus_retry | output | 1 | Retry request, tied low |
| bus_tout_sup | output | 1 | Timeout suppress, tied low |
| bus_err | output | 1 | Error acknowledge, tied low |
| start_pulse | output | 1 | One-cycle frame start to the engine |
| comp_count | output | 3 | Number of colour components |
| img_width | output | 16 | Frame width |
| img_height | output | 16 | Frame height |
| luma_we | output | 1 | Brightness table write strobe |
| chroma_we | output | 1 | Colour-difference table write strobe |
| tbl_idx | output | 6 | Table entry index for the strobes |
| tbl_data | output | 8 | Table entry value for the strobes |
| eng_done | input | 1 | Engine reports end of frame |

## Verification
Some rules hold in every cycle, and the embedded assertions check them all the time. The acknowledge never lasts two cycles and only follows a cycle with select high. The read bus is zero whenever there is no acknowledge. The start pulse lasts one cycle. The finished status is only ever entered from busy with the done input high. Other behaviour is only visible through scenarios, and the bench covers it. That includes the address decode, read-back of each register and table entry, keeping the two tables apart, the status sequence idle, busy, finished and busy again, silence under a long-held select, and writes to holes that leave every register unchanged.

// File: rtl/enc_host_regs.sv
module enc_host_regs #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int TBL_DEPTH = 64,
  parameter int QW        = 8,
  parameter int DIM_W     = 16,
  parameter int COMP_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W/8-1:0]       bus_be,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_rnw,
  input  logic                      bus_sel,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      bus_ack,
  output logic                      bus_retry,
  output logic                      bus_tout_sup,
  output logic                      bus_err,
  output logic                      start_pulse,
  output logic [COMP_W-1:0]         comp_count,
  output logic [DIM_W-1:0]          img_width,
  output logic [DIM_W-1:0]          img_height,
  output logic                      luma_we,
  output logic                      chroma_we,
  output logic [$clog2(TBL_DEPTH)-1:0] tbl_idx,
  output logic [QW-1:0]             tbl_data,
  input  logic                      eng_done
);
  localparam int IDX_W = $clog2(TBL_DEPTH);
  localparam int TSH   = IDX_W + 2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 'h0;
  localparam logic [ADDR_W-1:0] A_SIZE  = 'h4;
  localparam logic [ADDR_W-1:0] A_STAT  = 'hC;
  localparam logic [ADDR_W-1:0] A_LUMA  = 'h100;
  localparam logic [ADDR_W-1:0] A_CHROM = 'h200;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_DONE = 2'd2;

  logic              held_q;
  logic [DATA_W-1:0] ctrl_q, size_q, rd_val;
  logic [1:0]        stat_q;
  logic [QW-1:0]     luma_mem  [TBL_DEPTH];
  logic [QW-1:0]     chroma_mem[TBL_DEPTH];

  wire xfer      = bus_sel && !held_q;
  wire wr        = xfer && !bus_rnw;
  wire hit_ctrl  = bus_addr[ADDR_W-1:2] == A_CTRL[ADDR_W-1:2];
  wire hit_size  = bus_addr[ADDR_W-1:2] == A_SIZE[ADDR_W-1:2];
  wire hit_stat  = bus_addr[ADDR_W-1:2] == A_STAT[ADDR_W-1:2];
  wire hit_luma  = bus_addr[ADDR_W-1:TSH] == A_LUMA[ADDR_W-1:TSH];
  wire hit_chrom = bus_addr[ADDR_W-1:TSH] == A_CHROM[ADDR_W-1:TSH];
  wire [IDX_W-1:0] idx = bus_addr[TSH-1:2];
  wire go        = wr && hit_ctrl && bus_wdata[0];

  assign bus_retry    = 1'b0;
  assign bus_tout_sup = 1'b0;
  assign bus_err      = 1'b0;
  assign comp_count   = ctrl_q[COMP_W:1];
  assign img_width    = size_q[2*DIM_W-1:DIM_W];
  assign img_height   = size_q[DIM_W-1:0];

  always_comb begin
    rd_val = '0;
    if (hit_ctrl)       rd_val = ctrl_q;
    else if (hit_size)  rd_val = size_q;
    else if (hit_stat)  rd_val = DATA_W'(stat_q);
    else if (hit_luma)  rd_val = DATA_W'(luma_mem[idx]);
    else if (hit_chrom) rd_val = DATA_W'(chroma_mem[idx]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q      <= 1'b0;
      bus_ack     <= 1'b0;
      bus_rdata   <= '0;
      ctrl_q      <= '0;
      size_q      <= '0;
      stat_q      <= ST_IDLE;
      start_pulse <= 1'b0;
      luma_we     <= 1'b0;
      chroma_we   <= 1'b0;
      tbl_idx     <= '0;
      tbl_data    <= '0;
      for (int i = 0; i < TBL_DEPTH; i++) begin
        luma_mem[i]   <= '0;
        chroma_mem[i] <= '0;
      end
    end else begin
      held_q      <= bus_sel && (held_q || xfer);
      bus_ack     <= xfer;
      bus_rdata   <= (xfer && bus_rnw) ? rd_val : '0;
      start_pulse <= go;
      luma_we     <= wr && hit_luma;
      chroma_we   <= wr && hit_chrom;
      if (wr && (hit_luma || hit_chrom)) begin
        tbl_idx  <= idx;
        tbl_data <= bus_wdata[QW-1:0];
      end
      if (wr && hit_ctrl) ctrl_q <= bus_wdata;
      if (wr && hit_size) size_q <= bus_wdata;
      if (wr && hit_luma)  luma_mem[idx]   <= bus_wdata[QW-1:0];
      if (wr && hit_chrom) chroma_mem[idx] <= bus_wdata[QW-1:0];
      if (go) stat_q <= ST_BUSY;
      else if (stat_q == ST_BUSY && eng_done) stat_q <= ST_DONE;
    end
  end

  // R1
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);
  // R1
  ack_follows_sel_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_sel));
  // R2
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_ack |-> bus_rdata == '0);
  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);
  // R7
  done_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q == ST_DONE && $past(stat_q) != ST_DONE) |-> ($past(eng_done) && $past(stat_q) == ST_BUSY));
  // R9
  quiet_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_retry || bus_tout_sup || bus_err));
endmodule

// File: tb/enc_host_regs_test.sv
module enc_host_regs_test;
  logic        clk = 0, rst = 1;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [3:0]  bus_be = 0;
  logic        bus_rnw = 0, bus_sel = 0, bus_ack, bus_retry, bus_tout_sup, bus_err;
  logic        start_pulse, luma_we, chroma_we, eng_done = 0;
  logic [2:0]  comp_count;
  logic [15:0] img_width, img_height;
  logic [5:0]  tbl_idx;
  logic [7:0]  tbl_data;
  int nchk = 0, nbad = 0;
  bit finished = 0;

  enc_host_regs uut (.*);

  always #10 clk = ~clk;

  localparam int NV = 14;
  // {rnw, addr, wdata, expected read}
  localparam logic [96:0] VEC [NV] = '{
    {1'b0, 32'h004, 32'h0040_0020, 32'h0},
    {1'b1, 32'h004, 32'h0,         32'h0040_0020},
    {1'b0, 32'h100, 32'h0000_01AB, 32'h0},
    {1'b1, 32'h100, 32'h0,         32'h0000_00AB},
    {1'b0, 32'h1FC, 32'h0000_005C, 32'h0},
    {1'b1, 32'h1FC, 32'h0,         32'h0000_005C},
    {1'b0, 32'h214, 32'hFFFF_FF32, 32'h0},
    {1'b1, 32'h214, 32'h0,         32'h0000_0032},
    {1'b1, 32'h100, 32'h0,         32'h0000_00AB},
    {1'b1, 32'h008, 32'h0,         32'h0},
    {1'b1, 32'h400, 32'h0,         32'h0},
    {1'b0, 32'h000, 32'h0000_0006, 32'h0},
    {1'b1, 32'h000, 32'h0,         32'h0000_0006},
    {1'b1, 32'h00C, 32'h0,         32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] rd;
  int lat;
  logic s_start, s_lw, s_cw;
  logic [5:0] s_idx;
  logic [7:0] s_data;

  task automatic xfer(input logic rnw, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rnw = rnw; bus_addr = a; bus_wdata = d; bus_be = 4'hF;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!bus_ack && lat < 20);
    rd = bus_rdata; s_start = start_pulse; s_lw = luma_we; s_cw = chroma_we;
    s_idx = tbl_idx; s_data = tbl_data;
    bus_sel = 0; bus_rnw = 0; bus_addr = 0; bus_wdata = 0; bus_be = 0;
  endtask

  always @(negedge clk)
    if (!rst && (bus_retry || bus_tout_sup || bus_err)) begin
      nbad++;
      $display("FAIL R9: actual %b%b%b expected 000", bus_retry, bus_tout_sup, bus_err);
    end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 outputs", {bus_ack, start_pulse, luma_we, chroma_we, comp_count}, 0);
    chk("R10 rdata", bus_rdata, 0);
    chk("R10 size", {img_width, img_height}, 0);
    rst = 0;
    xfer(1, 32'hC, 0);  chk("R7 status after reset", rd, 0);
    xfer(1, 32'h0, 0);  chk("R10 ctrl readback", rd, 0);

    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][96], VEC[v][95:64], VEC[v][63:32]);
      chk("R1 ack latency", lat, 1);
      if (VEC[v][96]) chk("R2 R5 R6 R8 read data", rd, VEC[v][31:0]);
    end
    chk("R4 width", img_width, 16'h0040);
    chk("R4 height", img_height, 16'h0020);

    // R5 / R6 strobes
    xfer(0, 32'h128, 32'h77);
    chk("R5 strobe", {s_lw, s_cw, 2'b0, s_idx, s_data}, {1'b1, 1'b0, 2'b0, 6'd10, 8'h77});
    xfer(0, 32'h2FC, 32'h19);
    chk("R6 strobe", {s_lw, s_cw, 2'b0, s_idx, s_data}, {1'b0, 1'b1, 2'b0, 6'd63, 8'h19});
    xfer(1, 32'h1FC, 0); chk("R6 luma untouched", rd, 32'h5C);

    // R3 start and R7 status sequence
    xfer(0, 32'h0, 32'h7);
    chk("R3 start pulse", s_start, 1);
    @(negedge clk); chk("R3 start ends", start_pulse, 0);
    chk("R3 comp count", comp_count, 3);
    xfer(1, 32'hC, 0); chk("R7 busy", rd, 1);
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;
    xfer(1, 32'hC, 0); chk("R7 done", rd, 2);
    xfer(0, 32'h0, 32'h6); chk("R3 no start when bit0 clear", s_start, 0);
    xfer(1, 32'hC, 0); chk("R7 done holds", rd, 2);
    xfer(0, 32'h0, 32'h3);
    xfer(1, 32'hC, 0); chk("R7 busy again", rd, 1);

    // R8 writes to holes
    xfer(0, 32'h8, 32'hFFFF_FFFF); chk("R8 hole write acked", lat, 1);
    xfer(0, 32'h300, 32'hFFFF_FFFF);
    xfer(1, 32'h0, 0); chk("R8 ctrl unchanged", rd, 3);
    xfer(1, 32'h4, 0); chk("R8 size unchanged", rd, 32'h0040_0020);
    xfer(1, 32'h8, 0); chk("R8 hole reads zero", rd, 0);

    // R1 held select gives one acknowledge
    begin
      int acks = 0;
      @(negedge clk);
      bus_sel = 1; bus_rnw = 1; bus_addr = 32'h4; bus_be = 4'hF;
      for (int k = 0; k < 6; k++) begin @(negedge clk); if (bus_ack) acks++; end
      bus_sel = 0;
      chk("R1 single ack on held select", acks, 1);
      @(negedge clk); @(negedge clk);
      chk("R2 rdata idle", bus_rdata, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule